// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake

This block is a watchdog. It counts pulses from a slow oscillator that runs separately from the CPU clock, so it keeps counting while the CPU is asleep. The oscillator is modelled as a one-cycle tick-enable input. An 8-bit base counter overflows, and a postscaler divides those overflows by a power of two. Configuration inputs choose the ratio. When the count runs out while the CPU is awake, the block raises a one-cycle reset request. When the count runs out while the CPU is asleep, it raises a one-cycle wake pulse instead and leaves the sleep state.

The watchdog has two enables. A configuration input forces the watchdog on, and software cannot turn it off. When that input is low, bit 0 of an 8-bit control register turns the watchdog on or off. The CPU must service the watchdog with a clear strobe. The CPU also sends a sleep strobe when it goes to sleep. Both strobes restart the count and raise a time-out status flag. Every expiry lowers that flag again.

Top module: `wdt_sleepwake`

## Requirements
- R1: After reset `to_flag` is 1, `asleep` is 0, `reg_rdata` is 8'h00, and neither `rst_req` nor `wake_req` is asserted.
- R2: While `cfg_force_on` is 1 the watchdog counts and expires whatever the value of the software enable bit, including after software writes it to 0.
- R3: A write with `reg_we` stores `reg_wdata[0]` as the software enable bit. `reg_rdata[0]` returns that bit and `reg_rdata[7:1]` always reads 0.
- R4: While `cfg_force_on` and the software enable bit are both 0, the count is held at zero and no expiry happens. A later enable starts a complete period.
- R5: The period is 256 × 2^`cfg_post_sel` ticks after the last restart. The tick that completes it makes `rst_req` high for exactly the next clock cycle when the block is awake.
- R6: An expiry while `asleep` is 1 gives a one-cycle `wake_req` and no `rst_req`, and `asleep` returns to 0 at the same edge.
- R7: Every expiry, whether it leads to a reset or a wake, sets `to_flag` to 0.
- R8: A `clr_strobe` or `sleep_strobe` restarts the period from zero and sets `to_flag` to 1. Such a strobe takes precedence over a tick in the same cycle. `sleep_strobe` also sets `asleep`.
- R9: The count advances only in cycles where `tick_en` is 1. Irregular tick spacing stretches the period in clock cycles but not in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| tick_en | input | 1 | One-cycle pulse from the watchdog oscillator |
| cfg_force_on | input | 1 | Configuration enable; 1 keeps the watchdog running |
| cfg_post_sel | input | 3 | Postscaler select, ratio 2^value |
| clr_strobe | input | 1 | Watchdog service strobe from the CPU |
| sleep_strobe | input | 1 | Sleep entry strobe from the CPU |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_flag | output | 1 | Time-out status, 0 after an expiry |
| asleep | output | 1 | CPU sleep state tracked by the block |

## Verification
A behavioural tick-count model runs beside the design and is compared with it on every clock.

The count is driven three ways:
- A tick in every cycle pins the exact expiry cycle for the 256-tick period and for longer postscaler ratios, up to the largest ratio.
- A tick every third cycle separates counting in ticks from counting in clocks.
- Pseudo-random tick gaps catch errors that depend on the spacing of the ticks.

Enable is tried four ways:
- Forced on with the software bit cleared.
- Software on.
- Both off.
- A software enable given after a long disabled stretch, which shows whether the count was held at zero.

Periodic service strobes check that a serviced watchdog never fires. A sleep strobe followed by an expiry separates the wake path from the reset path.

// File: rtl/wdt_sleepwake.sv
module wdt_sleepwake #(
  parameter int BASE_W = 8,
  parameter int SEL_W  = 3,
  parameter int REG_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cfg_force_on,
  input  logic [SEL_W-1:0] cfg_post_sel,
  input  logic             clr_strobe,
  input  logic             sleep_strobe,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             rst_req,
  output logic             wake_req,
  output logic             to_flag,
  output logic             asleep
);

  localparam int POST_W = (1 << SEL_W) - 1;

  logic              sw_en;
  logic [BASE_W-1:0] base_q;
  logic [POST_W-1:0] post_q;
  logic [POST_W:0]   ratio;
  logic [POST_W-1:0] post_limit;
  logic              running, restart, base_full, post_last, expire;

  assign running    = cfg_force_on | sw_en;
  assign restart    = clr_strobe | sleep_strobe;
  assign ratio      = (POST_W + 1)'(1) << cfg_post_sel;
  assign post_limit = POST_W'(ratio - 1'b1);
  assign base_full  = &base_q;
  assign post_last  = (post_q == post_limit);
  assign expire     = running & ~restart & tick_en & base_full & post_last;
  assign reg_rdata  = {{(REG_W-1){1'b0}}, sw_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en <= 1'b0;
    end else if (reg_we) begin
      sw_en <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      post_q <= '0;
    end else if (!running || restart) begin
      base_q <= '0;
      post_q <= '0;
    end else if (tick_en) begin
      base_q <= base_q + 1'b1;
      if (base_full) post_q <= post_last ? '0 : post_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_flag  <= 1'b1;
      asleep   <= 1'b0;
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      rst_req  <= expire & ~asleep;
      wake_req <= expire & asleep;
      if (restart)     to_flag <= 1'b1;
      else if (expire) to_flag <= 1'b0;
      if (sleep_strobe) asleep <= 1'b1;
      else if (expire)  asleep <= 1'b0;
    end
  end

  assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req));
  assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_wake_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> !asleep);
  assert_to_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || wake_req) |-> !to_flag);
  assert_held_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (base_q == '0 && post_q == '0));
  assert_strobe_to_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> to_flag);

endmodule

// File: tb/wdt_sleepwake_test.sv
`timescale 1ns/1ps
module wdt_sleepwake_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic cfg_force_on = 1'b0;
  logic [2:0] cfg_post_sel = 3'd0;
  logic clr_strobe = 1'b0, sleep_strobe = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic rst_req, wake_req, to_flag, asleep;

  always #2.5 clk = ~clk;

  wdt_sleepwake uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_force_on(cfg_force_on),
    .cfg_post_sel(cfg_post_sel), .clr_strobe(clr_strobe), .sleep_strobe(sleep_strobe),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag), .asleep(asleep));

  int checks = 0, errors = 0, cycles = 0;
  int rst_cnt = 0, wake_cnt = 0;
  int tick_mode = 0, phase = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  bit m_sw = 0, m_to = 1, m_sleep = 0, m_rst = 0, m_wake = 0;
  int m_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    phase <= (phase == 2) ? 0 : phase + 1;
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tick_mode)
      0: tick_en <= 1'b1;
      1: tick_en <= (phase == 2);
      default: tick_en <= lfsr[0] & lfsr[3];
    endcase
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sw = 0; m_to = 1; m_sleep = 0; m_rst = 0; m_wake = 0; m_cnt = 0;
    end else begin
      bit en;
      en = cfg_force_on | m_sw;
      m_rst = 0; m_wake = 0;
      if (clr_strobe || sleep_strobe) begin
        m_cnt = 0; m_to = 1;
        if (sleep_strobe) m_sleep = 1;
      end else if (en && tick_en) begin
        m_cnt++;
        if (m_cnt == (256 << cfg_post_sel)) begin
          m_cnt = 0; m_to = 0;
          if (m_sleep) begin m_wake = 1; m_sleep = 0; end
          else m_rst = 1;
        end
      end
      if (!en) m_cnt = 0;
      if (reg_we) m_sw = reg_wdata[0];
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (rst_req) rst_cnt++;
      if (wake_req) wake_cnt++;
      chk(rst_req == m_rst, "R5 rst_req", rst_req, m_rst);
      chk(wake_req == m_wake, "R6 wake_req", wake_req, m_wake);
      chk(asleep == m_sleep, "R6 asleep", asleep, m_sleep);
      chk(to_flag == m_to, "R7 to_flag", to_flag, m_to);
      chk(reg_rdata == {7'd0, m_sw}, "R3 reg_rdata", reg_rdata, {7'd0, m_sw});
    end
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_clr(input bit slp);
    @(negedge clk);
    if (slp) sleep_strobe = 1'b1; else clr_strobe = 1'b1;
    @(negedge clk);
    sleep_strobe = 1'b0; clr_strobe = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1
    chk(to_flag === 1'b1, "R1 to_flag", to_flag, 1);
    chk(asleep === 1'b0 && rst_req === 1'b0 && wake_req === 1'b0, "R1 outputs", asleep, 0);
    chk(reg_rdata === 8'h00, "R1 reg_rdata", reg_rdata, 0);
    rst_n = 1'b1;

    // R2/R5: forced on, ratio 1, tick every cycle
    cfg_force_on = 1'b1;
    pulse_clr(0);
    rst_cnt = 0; idle(600);
    chk(rst_cnt == 2, "R5 pulses in 600 ticks", rst_cnt, 2);
    wr(8'h00);
    pulse_clr(0);
    rst_cnt = 0; idle(300);
    chk(rst_cnt == 1, "R2 forced on ignores sw bit", rst_cnt, 1);

    // R3/R4
    cfg_force_on = 1'b0;
    idle(1);
    rst_cnt = 0; idle(1200);
    chk(rst_cnt == 0, "R4 disabled no expiry", rst_cnt, 0);
    wr(8'hFF);
    idle(1);
    chk(reg_rdata == 8'h01, "R3 upper bits read 0", reg_rdata, 1);
    rst_cnt = 0; idle(250);
    chk(rst_cnt == 0, "R4 fresh period after enable", rst_cnt, 0);
    idle(50);
    chk(rst_cnt == 1, "R4 expiry after full period", rst_cnt, 1);

    // R8: serviced watchdog, ratio 4
    cfg_post_sel = 3'd2;
    pulse_clr(0);
    rst_cnt = 0;
    for (int k = 0; k < 6; k++) begin idle(800); pulse_clr(0); end
    chk(rst_cnt == 0, "R8 serviced never fires", rst_cnt, 0);

    // R6/R7: sleep then wake
    cfg_post_sel = 3'd0;
    pulse_clr(1);
    chk(asleep == 1'b1, "R8 sleep strobe sets asleep", asleep, 1);
    rst_cnt = 0; wake_cnt = 0; idle(300);
    chk(wake_cnt == 1 && rst_cnt == 0, "R6 wake not reset", wake_cnt, 1);
    chk(asleep == 1'b0, "R6 leaves sleep", asleep, 0);
    chk(to_flag == 1'b0, "R7 flag cleared", to_flag, 0);

    // R9: tick every third cycle, ratio 2
    cfg_post_sel = 3'd1;
    tick_mode = 1;
    pulse_clr(0);
    rst_cnt = 0; idle(1400);
    chk(rst_cnt == 0, "R9 slow ticks not yet", rst_cnt, 0);
    idle(300);
    chk(rst_cnt == 1, "R9 slow ticks expiry", rst_cnt, 1);

    // irregular ticks, ratio 1
    tick_mode = 2; cfg_post_sel = 3'd0;
    pulse_clr(0);
    idle(6000);

    // largest ratio
    tick_mode = 0; cfg_post_sel = 3'd7; cfg_force_on = 1'b1;
    pulse_clr(0);
    rst_cnt = 0; idle(32700);
    chk(rst_cnt == 0, "R5 ratio 128 not early", rst_cnt, 0);
    idle(200);
    chk(rst_cnt == 1, "R5 ratio 128 expiry", rst_cnt, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule